// File: doc/BRIEF.md
# Vertical Field Timer with 50/60 Hz Rate Detection

This block keeps vertical timing for a television sync path. A strobe arriving twice per line drives a 10-bit half-line counter. A vertical sync input that may carry noise restarts the counter, but only once the sync has been qualified. From the count the block decodes a vertical output pulse and a vertical blanking window. It also classifies every completed field as 50 Hz or 60 Hz from its length in half-lines.

The sync qualifier samples the raw sync only on strobe cycles. It has three states. `Q_IDLE` waits for a high sample. `Q_COUNT` counts consecutive high samples. It moves to `Q_HELD` on the eighth sample and emits one accept pulse. Any low sample in `Q_COUNT` or `Q_HELD` returns it to `Q_IDLE`. The counter restarts at zero on an accept only when its count is above 400. With no accepted sync it wraps on its own.

The rate machine has four states. `R_50` and `R_60` are the stable states. In `R_50`, a short field moves it to `R_50_PEND`; a long field keeps it in `R_50`. `R_50_PEND` moves to `R_60` on a short field and falls back to `R_50` on a long one. `R_60` and `R_60_PEND` are the mirror image.

Top module: `vfield_timer`

## Requirements
- R1: After reset the count is 0, `vout_pulse` and `vblank_win` are 1 and `rate_is_60` is 0.
- R2: Raw sync is sampled only in cycles where `half_line_tick` is 1. The counter restarts on the strobe that brings the eighth consecutive high sample. Seven high samples followed by a low one have no effect. High levels that occur only between strobes have no effect.
- R3: An accepted sync that arrives while the count is 400 or less is ignored, and the count keeps advancing.
- R4: A sync held high for a long time restarts the counter only once. It can restart it again only after a low sample.
- R5: `vout_pulse` is 1 exactly while the count is 0 to 9, that is, for 10 half-lines from the restart.
- R6: When `rate_is_60` is 0, `vblank_win` is 1 while the count is below 45 or at least 620.
- R7: When `rate_is_60` is 1, `vblank_win` is 1 while the count is below 34 or at least 519.
- R8: With no accepted sync, the counter wraps to 0 after 625 half-lines. The one exception: in 60 Hz mode, when the previous field also ended by wrapping, it wraps after 525 half-lines.
- R9: A field whose length (count at its end plus one) is 575 half-lines or more is classified 50 Hz. A field of 574 or fewer is classified 60 Hz.
- R10: `rate_is_60` (0 = 50 Hz, 1 = 60 Hz) changes only after two consecutive completed fields are both classified opposite to its present value. A single opposite field is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_line_tick | input | 1 | One-cycle strobe, twice per line |
| vsync_raw | input | 1 | Unfiltered vertical sync, active high |
| vout_pulse | output | 1 | Vertical output pulse |
| vblank_win | output | 1 | Vertical blanking window |
| rate_is_60 | output | 1 | Field rate: 0 for 50 Hz, 1 for 60 Hz |

## Verification
The assertions check several properties on every cycle:
- the count never passes the long wrap limit;
- the count never moves between strobes;
- the count never restarts while it is at or below the gate;
- the sync qualifier never accepts twice in a row;
- the rate flag moves only at a field end;
- the output pulse always lies inside the blanking window.

Other behaviour can only be shown by the bench's scenarios:
- the exact length of the qualification run and the handling of between-strobe glitches;
- the precise edges of both blanking windows;
- the short wrap in 60 Hz mode;
- the two-field hysteresis;
- classification on each side of the 575 boundary.

// File: rtl/vfield_pkg.sv
package vfield_pkg;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_COUNT = 2'd1,
        Q_HELD  = 2'd2
    } qual_state_t;

    typedef enum logic [1:0] {
        R_50      = 2'd0,
        R_50_PEND = 2'd1,
        R_60      = 2'd2,
        R_60_PEND = 2'd3
    } rate_state_t;

endpackage

// File: rtl/vfield_sync_qual.sv
module vfield_sync_qual
    import vfield_pkg::*;
#(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic vs_raw,
    output logic accept
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

    qual_state_t      st_q, st_d;
    logic [RUN_W-1:0] run_q, run_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= Q_IDLE;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (tick) begin
            unique case (st_q)
                Q_IDLE: begin
                    if (vs_raw) begin
                        if (RUN_LAST == '0) begin
                            st_d = Q_HELD;
                        end else begin
                            st_d  = Q_COUNT;
                            run_d = RUN_ONE;
                        end
                    end
                end
                Q_COUNT: begin
                    if (!vs_raw) begin
                        st_d  = Q_IDLE;
                        run_d = '0;
                    end else if (run_q == RUN_LAST) begin
                        st_d  = Q_HELD;
                        run_d = '0;
                    end else begin
                        run_d = run_q + RUN_ONE;
                    end
                end
                Q_HELD: begin
                    if (!vs_raw) st_d = Q_IDLE;
                end
                default: st_d = Q_IDLE;
            endcase
        end
    end

    always_comb begin
        accept = 1'b0;
        if (tick && vs_raw) begin
            unique case (st_q)
                Q_IDLE:  accept = (RUN_LAST == '0);
                Q_COUNT: accept = (run_q == RUN_LAST);
                Q_HELD:  accept = 1'b0;
                default: accept = 1'b0;
            endcase
        end
    end

    assert_single_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    assert_accept_in_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q == Q_HELD));

endmodule

// File: rtl/vfield_counter.sv
module vfield_counter #(
    parameter int CNT_W     = 10,
    parameter int LEN_50    = 625,
    parameter int LEN_60    = 525,
    parameter int MIN_RESET = 400,
    parameter int THRESH    = 575
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             accept,
    input  logic             short_std,
    output logic [CNT_W-1:0] cnt,
    output logic             field_done,
    output logic             field_long
);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LEN_50 - 1);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(LEN_60 - 1);
    localparam logic [CNT_W-1:0] GATE      = CNT_W'(MIN_RESET);
    localparam logic [CNT_W-1:0] THR_LAST  = CNT_W'(THRESH - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             free_q;
    logic             take_sync;
    logic             at_limit;

    assign take_sync = accept && (cnt_q > GATE);
    assign at_limit  = (cnt_q == ((short_std && free_q) ? LIM_SHORT : LIM_LONG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            free_q <= 1'b0;
        end else if (tick) begin
            if (take_sync) begin
                cnt_q  <= '0;
                free_q <= 1'b0;
            end else if (at_limit) begin
                cnt_q  <= '0;
                free_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign cnt        = cnt_q;
    assign field_done = tick && (take_sync || at_limit);
    assign field_long = (cnt_q >= THR_LAST);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_LONG);

    assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    assert_reset_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q <= GATE) |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/vfield_rate_fsm.sv
module vfield_rate_fsm
    import vfield_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic field_done,
    input  logic field_long,
    output logic std_60
);
    rate_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= R_50;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (field_done) begin
            unique case (st_q)
                R_50:      st_d = field_long ? R_50 : R_50_PEND;
                R_50_PEND: st_d = field_long ? R_50 : R_60;
                R_60:      st_d = field_long ? R_60_PEND : R_60;
                R_60_PEND: st_d = field_long ? R_50 : R_60;
                default:   st_d = R_50;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            R_60, R_60_PEND: std_60 = 1'b1;
            default:         std_60 = 1'b0;
        endcase
    end

    assert_flag_on_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !field_done |=> $stable(std_60));

endmodule

// File: rtl/vfield_timer.sv
module vfield_timer #(
    parameter int CNT_W      = 10,
    parameter int FILT_LEN   = 8,
    parameter int MIN_RESET  = 400,
    parameter int LEN_50     = 625,
    parameter int LEN_60     = 525,
    parameter int THRESH     = 575,
    parameter int VP_LEN     = 10,
    parameter int BL_POST_50 = 45,
    parameter int BL_PRE_50  = 5,
    parameter int BL_POST_60 = 34,
    parameter int BL_PRE_60  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_line_tick,
    input  logic vsync_raw,
    output logic vout_pulse,
    output logic vblank_win,
    output logic rate_is_60
);
    localparam logic [CNT_W-1:0] VP_END    = CNT_W'(VP_LEN);
    localparam logic [CNT_W-1:0] POST_50   = CNT_W'(BL_POST_50);
    localparam logic [CNT_W-1:0] START_50  = CNT_W'(LEN_50 - BL_PRE_50);
    localparam logic [CNT_W-1:0] POST_60   = CNT_W'(BL_POST_60);
    localparam logic [CNT_W-1:0] START_60  = CNT_W'(LEN_60 - BL_PRE_60);

    logic             accept;
    logic [CNT_W-1:0] cnt;
    logic             field_done;
    logic             field_long;
    logic             std_60;

    vfield_sync_qual #(.FILT_LEN(FILT_LEN)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (half_line_tick),
        .vs_raw (vsync_raw),
        .accept (accept)
    );

    vfield_counter #(
        .CNT_W     (CNT_W),
        .LEN_50    (LEN_50),
        .LEN_60    (LEN_60),
        .MIN_RESET (MIN_RESET),
        .THRESH    (THRESH)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (half_line_tick),
        .accept     (accept),
        .short_std  (std_60),
        .cnt        (cnt),
        .field_done (field_done),
        .field_long (field_long)
    );

    vfield_rate_fsm u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_done (field_done),
        .field_long (field_long),
        .std_60     (std_60)
    );

    always_comb begin
        vout_pulse = (cnt < VP_END);
        if (std_60) vblank_win = (cnt < POST_60) || (cnt >= START_60);
        else        vblank_win = (cnt < POST_50) || (cnt >= START_50);
        rate_is_60 = std_60;
    end

    assert_pulse_in_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vout_pulse |-> vblank_win);

    assert_pulse_after_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vout_pulse) |-> $past(field_done));

endmodule

// File: tb/vfield_timer_tb.sv
`timescale 1ns/1ps
module vfield_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic vs = 1'b0;
    logic vout_pulse, vblank_win, rate_is_60;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    vfield_timer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .half_line_tick (tick),
        .vsync_raw      (vs),
        .vout_pulse     (vout_pulse),
        .vblank_win     (vblank_win),
        .rate_is_60     (rate_is_60)
    );

    // behavioural reference model
    int m_cnt = 0;
    int m_run = 0;
    int m_std = 0;
    int m_pend = 0;
    int m_free = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_std = 0; m_pend = 0; m_free = 0;
        end else if (tick) begin
            int acc, done, len, lim, cls60;
            acc = 0; done = 0; len = 0;
            if (vs) begin
                if (m_run == 7) acc = 1;
                if (m_run < 8) m_run++;
            end else begin
                m_run = 0;
            end
            lim = (m_std == 1 && m_free == 1) ? 525 : 625;
            if (acc == 1 && m_cnt > 400) begin
                len = m_cnt + 1; m_cnt = 0; m_free = 0; done = 1;
            end else if (m_cnt == lim - 1) begin
                len = m_cnt + 1; m_cnt = 0; m_free = 1; done = 1;
            end else begin
                m_cnt++;
            end
            if (done == 1) begin
                cls60 = (len < 575) ? 1 : 0;
                if (cls60 == m_std) m_pend = 0;
                else if (m_pend == 1) begin m_std = cls60; m_pend = 0; end
                else m_pend = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic ep, eb, er;
            ep = (m_cnt < 10);
            eb = m_std ? (m_cnt < 34 || m_cnt >= 519) : (m_cnt < 45 || m_cnt >= 620);
            er = (m_std == 1);
            checks++;
            if (vout_pulse !== ep) begin
                errors++;
                $display("FAIL R5 cycle %0d vout_pulse actual=%0b expected=%0b", cycles, vout_pulse, ep);
            end
            if (vblank_win !== eb) begin
                errors++;
                $display("FAIL %s cycle %0d vblank_win actual=%0b expected=%0b",
                         m_std ? "R7" : "R6", cycles, vblank_win, eb);
            end
            if (rate_is_60 !== er) begin
                errors++;
                $display("FAIL R10 cycle %0d rate_is_60 actual=%0b expected=%0b", cycles, rate_is_60, er);
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic run(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            vs = v; tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic glitch(input int n);
        for (int i = 0; i < n; i++) begin
            vs = 1'b0; tick = 1'b1;
            @(negedge clk);
            tick = 1'b0; vs = 1'b1;
            repeat (3) @(negedge clk);
        end
        vs = 1'b0;
    endtask

    // from count 0, produce a field of len half-lines ended by a qualified sync
    task automatic field_sync(input int len);
        run(len - 8, 1'b0);
        run(8, 1'b1);
        vs = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL R8 watchdog actual=%0d cycles expected<150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 pulse", vout_pulse, 1'b1);
        chk("R1 blank", vblank_win, 1'b1);
        chk("R1 rate", rate_is_60, 1'b0);

        run(10, 1'b0);                              // count 10
        chk("R5 pulse ends", vout_pulse, 1'b0);
        run(34, 1'b0);                              // count 44
        chk("R6 blank post edge in", vblank_win, 1'b1);
        run(1, 1'b0);                               // count 45
        chk("R6 blank post edge out", vblank_win, 1'b0);
        run(12, 1'b1);                              // count 57, sync below gate
        vs = 1'b0;
        chk("R3 early sync ignored", vout_pulse, 1'b0);
        run(562, 1'b0);                             // count 619
        chk("R6 blank pre edge out", vblank_win, 1'b0);
        run(1, 1'b0);                               // count 620
        chk("R6 blank pre edge in", vblank_win, 1'b1);
        run(5, 1'b0);                               // wraps at 625 -> 0
        chk("R8 wrap 625", vout_pulse, 1'b1);

        run(500, 1'b0);                             // count 500
        run(7, 1'b1);                               // seven highs only
        run(1, 1'b0);                               // count 508
        chk("R2 seven samples ignored", vout_pulse, 1'b0);
        glitch(10);                                 // count 518
        chk("R2 between-strobe high ignored", vout_pulse, 1'b0);
        run(8, 1'b1);                               // accepted at count 525, len 526
        chk("R2 eighth sample restarts", vout_pulse, 1'b1);
        chk("R10 one short field no switch", rate_is_60, 1'b0);
        run(440, 1'b1);                             // held high, count 440
        vs = 1'b0;
        chk("R4 no second restart", vout_pulse, 1'b0);
        run(152, 1'b0);                             // count 592
        run(8, 1'b1);                               // accept at 599, len 600
        vs = 1'b0;
        chk("R9 600 long field", rate_is_60, 1'b0);

        field_sync(520);
        chk("R10 first short field", rate_is_60, 1'b0);
        field_sync(520);
        chk("R10 second short field switches", rate_is_60, 1'b1);

        run(33, 1'b0);                              // count 33
        chk("R7 blank post edge in", vblank_win, 1'b1);
        run(1, 1'b0);                               // count 34
        chk("R7 blank post edge out", vblank_win, 1'b0);
        run(484, 1'b0);                             // count 518
        chk("R7 blank pre edge out", vblank_win, 1'b0);
        run(1, 1'b0);                               // count 519
        chk("R7 blank pre edge in", vblank_win, 1'b1);
        run(105, 1'b0);                             // count 624, long limit after synced field
        chk("R8 no short wrap after synced field", vout_pulse, 1'b0);
        run(1, 1'b0);                               // wrap at 625
        chk("R8 wrap 625 in 60 mode", vout_pulse, 1'b1);
        chk("R10 single long field no switch", rate_is_60, 1'b1);
        run(524, 1'b0);                             // count 524
        chk("R8 before short wrap", vout_pulse, 1'b0);
        run(1, 1'b0);                               // wrap at 525
        chk("R8 short wrap 525", vout_pulse, 1'b1);

        field_sync(520);                            // clears free-run state
        field_sync(575);
        chk("R9 575 once no switch", rate_is_60, 1'b1);
        field_sync(574);
        chk("R9 574 is short, pending cleared", rate_is_60, 1'b1);
        field_sync(575);
        chk("R9 575 first of pair", rate_is_60, 1'b1);
        field_sync(575);
        chk("R9 575 pair switches to 50", rate_is_60, 1'b0);
        field_sync(574);
        chk("R9 574 once in 50 mode", rate_is_60, 1'b0);
        field_sync(600);
        chk("R10 pending forgotten", rate_is_60, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule